// File: doc/BRIEF.md
# Packed SIMD Multiply-Low Unit

This block multiplies two packed 256-bit operands lane by lane. Each 32-bit lane is treated as a signed integer. Only the low 32 bits of each 64-bit signed product are written back. A two-bit mode input chooses how the upper 128 bits of the result are formed:

- They are copied from the first source, which doubles as the old destination value.
- They are forced to zero.
- They are computed as four further lanes, so the full 256-bit vector is multiplied.

The fourth mode code is illegal. It yields an all-zero result and raises a flag.

Operands enter through a valid/ready handshake. A small controller with three named states sequences the work:

- `S_IDLE`: waits for an operation.
- `S_CALC`: the captured operands pass through the lane multipliers and the upper-half merge.
- `S_HOLD`: presents the registered result until the consumer accepts it.

The transitions are:

- accept: `S_IDLE` to `S_CALC`, on `in_valid` while ready.
- compute: `S_CALC` to `S_HOLD`, always.
- drain: `S_HOLD` to `S_IDLE`, when `out_ready` is high and no new operation is offered.
- chain: `S_HOLD` to `S_CALC`, when `out_ready` and `in_valid` are both high, so the next operation is accepted in the same cycle the result leaves.

Top module: `simd_mullo_unit`

## Requirements
- R1: For every legal mode, result lane k (bits [32k+31:32k], k = 0..3) equals the low 32 bits of the signed product of the same lanes of `src_a` and `src_b`.
- R2: Signed corner values give the correctly truncated product, for example 0x80000000 × 0xFFFFFFFF = 0x80000000, 0xFFFFFFFF × 0xFFFFFFFF = 0x00000001 and 0x7FFFFFFF × 0x7FFFFFFF = 0x00000001.
- R3: With `in_mode` = 2'b00 (keep), result bits [255:128] equal `src_a[255:128]` as captured with the operation, and `src_b[255:128]` has no effect.
- R4: With `in_mode` = 2'b01 (clear), result bits [255:128] are zero whatever the upper halves of the sources hold.
- R5: With `in_mode` = 2'b10 (wide), lanes 4..7 follow the same low-32-bit signed product rule as lanes 0..3.
- R6: With `in_mode` = 2'b11, the result is all zero and `out_illegal` is high while that result is valid. For legal modes `out_illegal` stays low.
- R7: If an operation is accepted in cycle c, `out_valid` is low in cycle c+1 and high in cycle c+2.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low, so any offered operation is ignored.
- R9: During and immediately after reset, `out_valid` and `out_illegal` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts the offered operation this cycle |
| in_mode | input | 2 | 00 keep upper, 01 clear upper, 10 full width, 11 illegal |
| src_a | input | 256 | First source, also the previous destination value |
| src_b | input | 256 | Second source |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Packed low-half products, upper half per mode |
| out_illegal | output | 1 | Presented result came from the illegal mode code |

## Verification
A result is due exactly two cycles after the cycle in which its operation was accepted. The bench drives inputs on falling edges. It checks that `out_valid` is still low one falling edge after acceptance, and it compares `out_data` and `out_illegal` against its own signed reference model on the next falling edge. For the stall test, `out_ready` is held low across several cycles. The held data and the low `in_ready` are sampled on each of those falling edges. The bench then confirms that the operation offered during the stall never produces a result.

// File: rtl/simd_mullo_pkg.sv
package simd_mullo_pkg;
    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_ZERO = 2'b01,
        MODE_WIDE = 2'b10,
        MODE_BAD  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_CALC = 2'b01,
        S_HOLD = 2'b10
    } state_e;
endpackage

// File: rtl/simd_mullo_lane.sv
module simd_mullo_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    output logic [LANE_W-1:0] prod_lo
);
    // The low half of a two's-complement product does not depend on signedness.
    assign prod_lo = op_a * op_b;
endmodule

// File: rtl/simd_mullo_array.sv
module simd_mullo_array #(
    parameter int LANE_W = 32,
    parameter int LANES  = 8
) (
    input  logic [LANE_W*LANES-1:0] vec_a,
    input  logic [LANE_W*LANES-1:0] vec_b,
    output logic [LANE_W*LANES-1:0] vec_p
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        simd_mullo_lane #(.LANE_W(LANE_W)) u_lane (
            .op_a   (vec_a[k*LANE_W +: LANE_W]),
            .op_b   (vec_b[k*LANE_W +: LANE_W]),
            .prod_lo(vec_p[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_mullo_merge.sv
module simd_mullo_merge #(
    parameter int VEC_W = 256
) (
    input  simd_mullo_pkg::mode_e mode,
    input  logic [VEC_W-1:0]      prod,
    input  logic [VEC_W-1:0]      old_dst,
    output logic [VEC_W-1:0]      result,
    output logic                  illegal
);
    import simd_mullo_pkg::*;
    localparam int HALF_W = VEC_W / 2;

    always_comb begin
        result  = '0;
        illegal = 1'b0;
        unique case (mode)
            MODE_KEEP: begin
                result[HALF_W-1:0]     = prod[HALF_W-1:0];
                result[VEC_W-1:HALF_W] = old_dst[VEC_W-1:HALF_W];
            end
            MODE_ZERO: result[HALF_W-1:0] = prod[HALF_W-1:0];
            MODE_WIDE: result = prod;
            MODE_BAD:  illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/simd_mullo_unit.sv
module simd_mullo_unit #(
    parameter int LANE_W = 32,
    parameter int LANES  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [1:0]                in_mode,
    input  logic [LANE_W*LANES-1:0]   src_a,
    input  logic [LANE_W*LANES-1:0]   src_b,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [LANE_W*LANES-1:0]   out_data,
    output logic                      out_illegal
);
    import simd_mullo_pkg::*;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int HALF_W = VEC_W / 2;

    state_e            state_q, state_d;
    logic              accept, load_res;
    logic [VEC_W-1:0]  a_q, b_q, prod, merged, res_q;
    mode_e             mode_q;
    logic              bad_c, bad_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_res  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) state_d = S_CALC;
            end
            S_CALC: begin
                load_res = 1'b1;
                state_d  = S_HOLD;
            end
            S_HOLD: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready) state_d = in_valid ? S_CALC : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= MODE_KEEP;
        end else if (accept) begin
            a_q    <= src_a;
            b_q    <= src_b;
            mode_q <= mode_e'(in_mode);
        end
    end

    simd_mullo_array #(.LANE_W(LANE_W), .LANES(LANES)) u_array (
        .vec_a(a_q),
        .vec_b(b_q),
        .vec_p(prod)
    );

    simd_mullo_merge #(.VEC_W(VEC_W)) u_merge (
        .mode   (mode_q),
        .prod   (prod),
        .old_dst(a_q),
        .result (merged),
        .illegal(bad_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            bad_q <= 1'b0;
        end else if (load_res) begin
            res_q <= merged;
            bad_q <= bad_c;
        end
    end

    assign out_data    = res_q;
    assign out_illegal = out_valid && bad_q;

    // R8: stalled result holds and no new operation is taken
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    // R7: fixed two-cycle latency
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid);
    // R6: illegal code yields zeros
    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_valid && out_data == '0));
    // R4: clear mode zeroes upper half
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'b01) |=> ##1 (out_data[VEC_W-1:HALF_W] == '0));
    // R3: keep mode passes old destination upper half
    p_upper_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'b00) |=> ##1
            (out_data[VEC_W-1:HALF_W] == $past(src_a[VEC_W-1:HALF_W], 2)));
endmodule

// File: tb/simd_mullo_unit_test.sv
module simd_mullo_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    localparam logic [31:0] TA [NV] = '{32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFF,
                                        32'h80000000, 32'h80000000, 32'hFFFFFFFF, 32'h7FFFFFFF,
                                        32'h00010000, 32'h12345678, 32'hDEADBEEF, 32'h00000002};
    localparam logic [31:0] TB [NV] = '{32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFF,
                                        32'hFFFFFFFF, 32'h80000000, 32'h80000000, 32'h00000002,
                                        32'h00010000, 32'h00000000, 32'h00000003, 32'hC0000000};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic [1:0] in_mode = 2'b00;
    logic [255:0] src_a = '0, src_b = '0;
    logic in_ready, out_valid, out_illegal;
    logic [255:0] out_data;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_mullo_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
    );

    function automatic logic [255:0] model(logic [1:0] m, logic [255:0] a, logic [255:0] b);
        logic [255:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            logic signed [63:0] t;
            t = 64'($signed(a[32*k +: 32])) * 64'($signed(b[32*k +: 32]));
            r[32*k +: 32] = t[31:0];
        end
        case (m)
            2'b00: r[255:128] = a[255:128];
            2'b01: r[255:128] = '0;
            2'b10: ;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One operation: offer, accept, then sample at c+1 and c+2.
    task automatic run_op(logic [1:0] m, logic [255:0] a, logic [255:0] b, string req);
        logic [255:0] exp;
        exp = model(m, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; src_a = a; src_b = b; out_ready = 1'b1;
        check(in_ready == 1'b1, "R7 ready", {255'd0, in_ready}, 256'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R7 early", {255'd0, out_valid}, 256'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7 due", {255'd0, out_valid}, 256'd1);
        check(out_data == exp, req, out_data, exp);
        check(out_illegal == (m == 2'b11), "R6 flag", {255'd0, out_illegal}, {255'd0, m == 2'b11});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [255:0] a, b, exp, held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0 && out_illegal == 1'b0, "R9 outputs in reset",
              {254'd0, out_valid, out_illegal}, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R9 after reset",
              {254'd0, in_ready, out_valid}, 256'd2);

        // Vector table walk: R1 lanes 0..3, R5 upper lanes, R3/R4 upper handling
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < 8; k++) begin
                a[32*k +: 32] = TA[(i + k) % NV];
                b[32*k +: 32] = TB[(i + k) % NV];
            end
            run_op(2'(i % 3), a, b, (i % 3 == 0) ? "R1/R3 table" :
                                    (i % 3 == 1) ? "R1/R4 table" : "R1/R5 table");
        end

        // R2: signed corner lanes written out explicitly
        a = {128'h0123456789ABCDEF_FEDCBA9876543210,
             32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000005, 32'h80000000};
        b = {128'hFFFF0000FFFF0000_AAAA5555AAAA5555,
             32'h7FFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'hFFFFFFFF};
        exp = {128'h0123456789ABCDEF_FEDCBA9876543210,
               32'h00000001, 32'h00000001, 32'hFFFFFFF1, 32'h80000000};
        run_op(2'b00, a, b, "R2 corners keep");
        check(out_data == exp, "R2 literal", out_data, exp);
        // R3: second source upper half has no effect
        run_op(2'b00, a, ~b, "R3 src_b upper ignored");
        check(out_data[255:128] == a[255:128], "R3 upper kept", {128'd0, out_data[255:128]}, {128'd0, a[255:128]});
        // R4: clear mode with non-zero upper sources
        run_op(2'b01, a, b, "R4 clear");
        check(out_data[255:128] == '0, "R4 upper zero", out_data, {128'd0, exp[127:0]});
        // R5: wide mode with corner lanes placed in upper half
        run_op(2'b10, {a[127:0], a[127:0]}, {b[127:0], b[127:0]}, "R5 wide");
        check(out_data == {exp[127:0], exp[127:0]}, "R5 literal", out_data, {exp[127:0], exp[127:0]});
        // R6: illegal mode
        run_op(2'b11, a, b, "R6 illegal zero");

        // Random operands in all modes
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < 8; k++) begin
                a[32*k +: 32] = $urandom;
                b[32*k +: 32] = $urandom;
            end
            run_op(2'(n % 4), a, b, "R1 random");
        end

        // R8: stall with a competing offer
        a = {8{32'h80000000}}; b = {8{32'h00000003}};
        exp = model(2'b10, a, b);
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b10; src_a = a; src_b = b; out_ready = 1'b0;
        @(negedge clk);
        in_mode = 2'b01; src_a = ~a; src_b = ~b;
        @(negedge clk);
        held = out_data;
        check(out_valid == 1'b1 && held == exp, "R8 result", held, exp);
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check(out_valid == 1'b1 && in_ready == 1'b0 && out_data == held, "R8 hold",
                  out_data, held);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 offer ignored", {255'd0, out_valid}, 256'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 no late result", {255'd0, out_valid}, 256'd0);

        // R9: reset mid-operation
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b10; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_illegal == 1'b0 && in_ready == 1'b1, "R9 reset flush",
              {253'd0, out_valid, out_illegal, in_ready}, 256'd1);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule